// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Selector

This block gathers interrupt requests from a bank of priority slots, picks the highest-priority slot that is allowed to interrupt, and presents the word address of that slot's handler vector to the CPU. Slot index p maps straight to the vector address `VEC_BASE + 2*p`, so the CPU can fetch the handler pointer without any lookup table. Each slot collects several source flags, and the slot is pending while any of them is set. The lowest slots are reserved and never raise a request.

The CPU sees a registered vector address and a valid strobe. Valid stays high while a request is pending. When the CPU asserts accept, valid drops for one cycle and a one-cycle acknowledge pulse goes to the slot that was shown. The global interrupt enable gates ordinary slots. The top slots and any slot marked non-maskable bypass it. If the reset slot is pending while the reset vector word is flagged as blank, the block asks for the deepest sleep state instead of presenting a vector.

Top module: `irq_vector_sel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `vec_valid_o`, `ack_o` and `lpm_req_o` are 0 and `vec_addr_o` is the reset slot address (0xFFFE with defaults).
- R2: One cycle after the inputs present eligible slots, `vec_valid_o` is 1 and `vec_addr_o` equals `VEC_BASE + 2*p`, where p is the highest eligible slot index. Slot 31 is the highest and 0 the lowest, so the address bit 0 is always 0.
- R3: A slot is pending when any one of its `SRC_PER_SLOT` source bits is 1. Source bit m of slot p is `src_i[p*SRC_PER_SLOT + m]`.
- R4: Slots below `RSVD_SLOTS` (0 to 13 by default) never produce a valid vector, whatever their source bits are.
- R5: While `gie_i` is 0, a pending slot is eligible only if it is one of the top `ALWAYS_ON` slots (30 and 31) or its `nmask_i` bit is 1.
- R6: With its request held and no accept, `vec_valid_o` stays high. In the cycle after `accept_i` is sampled high with `vec_valid_o` high, `vec_valid_o` is 0 and `ack_o` has exactly the bit of the displayed slot set, for one cycle only.
- R7: When no slot is eligible, `vec_valid_o` is 0 and `vec_addr_o` keeps its previous value.
- R8: When the top slot is pending and `rst_vec_blank_i` is 1, `lpm_req_o` is 1 and `vec_valid_o` is 0 one cycle later. `rst_vec_blank_i` has no effect while the top slot is idle.
- R9: `ack_o` has at most one bit set and is all-zero unless accept was sampled with valid high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SLOTS*SRC_PER_SLOT | Source flags, grouped per slot |
| nmask_i | input | NUM_SLOTS | Per-slot non-maskable attribute |
| gie_i | input | 1 | Global interrupt enable |
| rst_vec_blank_i | input | 1 | Reset vector word reads as erased |
| accept_i | input | 1 | CPU takes the presented vector |
| vec_addr_o | output | VEC_W | Handler vector word address |
| vec_valid_o | output | 1 | Vector address is valid |
| ack_o | output | NUM_SLOTS | One-cycle acknowledge to the winning slot |
| lpm_req_o | output | 1 | Request to enter the deepest sleep state |

## Verification
The bench builds the block with its defaults: 32 slots, three sources per slot, 14 reserved slots and two always-eligible slots. This setup is small enough to drive every source bit of every slot on its own and every ordered pair of a non-reserved slot over a lower slot. It also sweeps every slot with the global enable off, both with and without the non-maskable attribute. Further runs cover the accept handshake, pre-emption by a higher slot, holding the vector when no slot is eligible, and the blank reset vector with and without the top slot pending.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int VEC_W = 16;
  typedef logic [VEC_W-1:0] vec_addr_t;

  // word address of the handler pointer for a slot index
  function automatic vec_addr_t slot_vector(input vec_addr_t base, input vec_addr_t idx);
    return base + (idx << 1);
  endfunction
endpackage

// File: rtl/irq_slot_gather.sv
module irq_slot_gather #(
  parameter int NUM_SLOTS    = 32,
  parameter int SRC_PER_SLOT = 3,
  parameter int RSVD_SLOTS   = 14
) (
  input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] src_i,
  output logic [NUM_SLOTS-1:0]              pend_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s < RSVD_SLOTS) begin : g_rsvd
      assign pend_o[s] = 1'b0;
    end else begin : g_live
      assign pend_o[s] = |src_i[s*SRC_PER_SLOT +: SRC_PER_SLOT];
    end
  end
endmodule

// File: rtl/irq_elig_filter.sv
module irq_elig_filter #(
  parameter int NUM_SLOTS = 32,
  parameter int ALWAYS_ON = 2
) (
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic [NUM_SLOTS-1:0] nmask_i,
  input  logic                 gie_i,
  output logic [NUM_SLOTS-1:0] elig_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s >= NUM_SLOTS - ALWAYS_ON) begin : g_top
      assign elig_o[s] = pend_i[s];
    end else begin : g_mask
      assign elig_o[s] = pend_i[s] & (gie_i | nmask_i[s]);
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] elig_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (elig_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |elig_i;
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
  import irq_sel_pkg::*;
#(
  parameter int        NUM_SLOTS    = 32,
  parameter int        SRC_PER_SLOT = 3,
  parameter int        RSVD_SLOTS   = 14,
  parameter int        ALWAYS_ON    = 2,
  parameter vec_addr_t VEC_BASE     = 16'hFFC0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] src_i,
  input  logic [NUM_SLOTS-1:0]              nmask_i,
  input  logic                              gie_i,
  input  logic                              rst_vec_blank_i,
  input  logic                              accept_i,
  output logic [VEC_W-1:0]                  vec_addr_o,
  output logic                              vec_valid_o,
  output logic [NUM_SLOTS-1:0]              ack_o,
  output logic                              lpm_req_o
);
  localparam int        IDX_W   = $clog2(NUM_SLOTS);
  localparam vec_addr_t RST_VEC = slot_vector(VEC_BASE, vec_addr_t'(NUM_SLOTS - 1));
  localparam vec_addr_t MIN_VEC = slot_vector(VEC_BASE, vec_addr_t'(RSVD_SLOTS));

  logic [NUM_SLOTS-1:0] pend, elig;
  logic                 any_elig;
  logic [IDX_W-1:0]     win_idx, win_q;
  logic                 sleep_cond;

  irq_slot_gather #(
    .NUM_SLOTS(NUM_SLOTS), .SRC_PER_SLOT(SRC_PER_SLOT), .RSVD_SLOTS(RSVD_SLOTS)
  ) u_gather (
    .src_i(src_i), .pend_o(pend)
  );

  irq_elig_filter #(
    .NUM_SLOTS(NUM_SLOTS), .ALWAYS_ON(ALWAYS_ON)
  ) u_filter (
    .pend_i(pend), .nmask_i(nmask_i), .gie_i(gie_i), .elig_o(elig)
  );

  irq_prio_enc #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_enc (
    .elig_i(elig), .any_o(any_elig), .idx_o(win_idx)
  );

  // top slot pending with an erased reset pointer: sleep instead of vectoring
  assign sleep_cond = pend[NUM_SLOTS-1] & rst_vec_blank_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid_o <= 1'b0;
      vec_addr_o  <= RST_VEC;
      win_q       <= IDX_W'(NUM_SLOTS - 1);
      ack_o       <= '0;
      lpm_req_o   <= 1'b0;
    end else begin
      ack_o     <= '0;
      lpm_req_o <= sleep_cond;
      if (vec_valid_o && accept_i) begin
        vec_valid_o  <= 1'b0;
        ack_o[win_q] <= 1'b1;
      end else if (any_elig && !sleep_cond) begin
        vec_valid_o <= 1'b1;
        vec_addr_o  <= slot_vector(VEC_BASE, vec_addr_t'(win_idx));
        win_q       <= win_idx;
      end else begin
        vec_valid_o <= 1'b0;
      end
    end
  end

  // R9
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o));

  // R6
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> $past(accept_i && vec_valid_o));

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |=> (ack_o == '0));

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(any_elig)) |-> ($stable(vec_addr_o) && !vec_valid_o));

  // R4
  no_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> (vec_addr_o >= MIN_VEC));

  // R2
  vec_even_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> (vec_addr_o[0] == 1'b0));

  // R8
  sleep_novec_chk: assert property (@(posedge clk) disable iff (rst)
    lpm_req_o |-> !vec_valid_o);
endmodule

// File: tb/irq_vector_sel_tb.sv
module irq_vector_sel_tb;
  localparam int CLK_NS = 10;
  localparam int NS     = 32;
  localparam int SPS    = 3;
  localparam int RSVD   = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS*SPS-1:0] src;
  logic [NS-1:0]     nmask;
  logic              gie, blank, accept;
  logic [15:0]       vec;
  logic              valid, lpm;
  logic [NS-1:0]     ack;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_vector_sel u_dut (
    .clk(clk), .rst(rst), .src_i(src), .nmask_i(nmask), .gie_i(gie),
    .rst_vec_blank_i(blank), .accept_i(accept),
    .vec_addr_o(vec), .vec_valid_o(valid), .ack_o(ack), .lpm_req_o(lpm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_vec(input int p);
    return 32'hFFC0 + 32'(2 * p);
  endfunction

  task automatic clear_in();
    src = '0; nmask = '0; gie = 1'b1; blank = 1'b0; accept = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_vec;
    clear_in();
    @(negedge clk);
    step(); step();
    chk("R1 valid", 32'(valid), 0);
    chk("R1 ack", 32'(ack), 0);
    chk("R1 lpm", 32'(lpm), 0);
    chk("R1 vec", 32'(vec), 32'hFFFE);
    rst = 1'b0;
    step();
    chk("R1 vec after release", 32'(vec), 32'hFFFE);

    // every source bit of every slot alone
    for (int p = 0; p < NS; p++) begin
      for (int m = 0; m < SPS; m++) begin
        last_vec = 32'(vec);
        src = '0;
        src[p*SPS + m] = 1'b1;
        step();
        if (p >= RSVD) begin
          chk("R3 member valid", 32'(valid), 1);
          chk("R2 single vec", 32'(vec), exp_vec(p));
          last_vec = 32'(vec);
        end else begin
          chk("R4 reserved valid", 32'(valid), 0);
          chk("R4 reserved vec", 32'(vec), last_vec);
        end
        src = '0;
        step();
        chk("R7 idle valid", 32'(valid), 0);
        chk("R7 idle vec", 32'(vec), last_vec);
      end
    end

    // every pair: higher live slot against any lower slot
    for (int a = RSVD; a < NS; a++) begin
      for (int b = 0; b < a; b++) begin
        src = '0;
        src[a*SPS + (a % SPS)] = 1'b1;
        src[b*SPS + (b % SPS)] = 1'b1;
        step();
        chk("R2 pair vec", 32'(vec), exp_vec(a));
        chk("R2 pair valid", 32'(valid), 1);
      end
    end
    src = '0;
    step();

    // global enable off
    gie = 1'b0;
    for (int p = 0; p < NS; p++) begin
      src = '0; nmask = '0;
      src[p*SPS] = 1'b1;
      step();
      chk("R5 masked valid", 32'(valid), (p >= NS - 2) ? 1 : 0);
      nmask[p] = 1'b1;
      step();
      chk("R5 nmask valid", 32'(valid), (p >= RSVD) ? 1 : 0);
      src = '0; nmask = '0;
      step();
    end
    src[20*SPS] = 1'b1; src[25*SPS] = 1'b1; nmask[20] = 1'b1;
    step();
    chk("R5 nmask beats masked higher", 32'(vec), exp_vec(20));
    clear_in();
    step();

    // accept handshake
    src[22*SPS + 1] = 1'b1;
    step();
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 held valid", 32'(valid), 1);
    end
    accept = 1'b1;
    step();
    chk("R6 valid drop", 32'(valid), 0);
    chk("R6 ack slot", 32'(ack), 32'(1) << 22);
    accept = 1'b0; src = '0;
    step();
    chk("R6 ack one cycle", 32'(ack), 0);
    chk("R6 valid after", 32'(valid), 0);
    accept = 1'b1;
    step();
    chk("R9 no ack without valid", 32'(ack), 0);
    accept = 1'b0;

    // pre-emption by a higher slot before accept
    src[18*SPS] = 1'b1;
    step();
    chk("R2 first vec", 32'(vec), exp_vec(18));
    src[27*SPS + 2] = 1'b1;
    step();
    chk("R2 preempt vec", 32'(vec), exp_vec(27));
    accept = 1'b1;
    step();
    chk("R9 ack preempt", 32'(ack), 32'(1) << 27);
    clear_in();
    step();

    // blank reset vector
    blank = 1'b1;
    src[31*SPS + 1] = 1'b1; src[25*SPS] = 1'b1;
    step();
    chk("R8 lpm", 32'(lpm), 1);
    chk("R8 no valid", 32'(valid), 0);
    blank = 1'b0;
    step();
    chk("R8 lpm off", 32'(lpm), 0);
    chk("R8 reset vec", 32'(vec), 32'hFFFE);
    src = '0; blank = 1'b1;
    src[25*SPS] = 1'b1;
    step();
    chk("R8 blank ignored lpm", 32'(lpm), 0);
    chk("R8 blank ignored vec", 32'(vec), exp_vec(25));
    clear_in();
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule